// File: doc/BRIEF.md
# Serial Receive Buffer with Held-Frame Overrun

This block sits between the bit-level part of an asynchronous serial receiver and the processor. When the receiver finishes assembling a character, it presents that character together with its frame-error and parity-error indications. The buffer stores each character with its status in a small first-in first-out queue. The processor reads the status of the oldest character first. It then reads the data, and that read removes the character.

When the queue is full, one more completed character is kept in a holding slot that stands for the receive shift register. This gives a third level of buffering. An overrun is only declared when a further start bit arrives while the queue and the holding slot are both occupied and no read is freeing space in that same cycle. When that happens, the held character is kept and the later character is thrown away. The overrun mark then travels with the next character that enters the queue. Clearing the enable empties everything.

Top module: `serial_rx_buffer`

## Requirements
- R1: After synchronous reset, rx_done is 0 and rx_data, rx_ferr, rx_perr and rx_ovr are all 0.
- R2: Completed frames enter a queue of DEPTH entries (default 2) and leave it in arrival order. rx_data shows the oldest entry.
- R3: The frame-error and parity-error flags given with a frame are stored with that frame and appear on rx_ferr and rx_perr while it is the oldest entry.
- R4: rx_done is 1 exactly when the queue holds at least one entry.
- R5: A data_rd pulse removes the oldest entry. A data_rd pulse while the queue is empty changes nothing.
- R6: A frame that completes while the queue is full and the holding slot is empty is kept in the holding slot.
- R7: In the cycle after the queue has a free place, the held frame moves into the queue ahead of any newer frame. A frame completing in that same cycle takes the holding slot.
- R8: A start_seen pulse raises an overrun only if the queue is full, the holding slot is occupied and no data_rd pop happens in that cycle.
- R9: A frame that completes while the queue is full and the holding slot is occupied is discarded, and the held frame is kept.
- R10: A raised overrun is written as rx_ovr=1 into the next entry that enters the queue, and is then cleared.
- R11: While rx_en is 0, the queue, the holding slot and any raised overrun are emptied, and frame, start and read inputs are ignored.
- R12: While the queue is empty, rx_data, rx_ferr, rx_perr and rx_ovr read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 flushes all buffered state |
| frm_valid | input | 1 | One-cycle pulse: a frame has been assembled |
| frm_data | input | 9 | Assembled frame data |
| frm_ferr | input | 1 | Frame error of the assembled frame |
| frm_perr | input | 1 | Parity error of the assembled frame |
| start_seen | input | 1 | One-cycle pulse: a new start bit was detected |
| data_rd | input | 1 | One-cycle pulse: processor reads data and pops |
| rx_data | output | 9 | Data of the oldest entry |
| rx_ferr | output | 1 | Frame error of the oldest entry |
| rx_perr | output | 1 | Parity error of the oldest entry |
| rx_ovr | output | 1 | Overrun mark of the oldest entry |
| rx_done | output | 1 | Receive complete: queue not empty |

## Verification
Two pairs of events can land in the same clock and need care. The first pair is a start bit and a processor read. The bench fills the queue and the holding slot, then pulses start_seen and data_rd together. It then expects that no overrun reaches any later entry. The second pair is a held frame moving into the queue while a new frame completes. The bench pops one entry, then delivers a frame in the cycle the held frame moves. It then expects the held frame next in order and the new frame behind it.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    parameter int DATA_W = 9;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
        logic              ovr;
    } rxb_entry_t;

    localparam rxb_entry_t RXB_EMPTY = '0;

    function automatic rxb_entry_t rxb_mark_ovr(rxb_entry_t e, logic o);
        rxb_entry_t r;
        r     = e;
        r.ovr = o;
        return r;
    endfunction

endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  rxb_entry_t       push_ent,
    input  logic             pop,
    output rxb_entry_t       head_ent,
    output logic [CNT_W-1:0] count
);

    rxb_entry_t       slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= RXB_EMPTY;
            end else if (push && wr_ptr == PTR_W'(i)) begin
                slot[i] <= push_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_ent = slot[rd_ptr];

endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
    import rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       load,
    input  rxb_entry_t load_ent,
    input  logic       unload,
    output logic       valid,
    output rxb_entry_t ent
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= 1'b0;
            ent   <= RXB_EMPTY;
        end else if (load) begin
            valid <= 1'b1;
            ent   <= load_ent;
        end else if (unload) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/rxb_route.sv
module rxb_route
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             frm_in,
    input  rxb_entry_t       frm_ent,
    input  logic             start_in,
    input  logic             rd_in,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             hold_v,
    input  rxb_entry_t       hold_ent,
    output logic             fifo_push,
    output rxb_entry_t       fifo_ent,
    output logic             fifo_pop,
    output logic             hold_load,
    output logic             hold_unload,
    output logic             ovr_pend
);

    logic room;
    logic move;
    logic arrive;
    logic direct;
    logic ovr_evt;

    always_comb begin
        room        = fifo_cnt < CNT_W'(DEPTH);
        fifo_pop    = en && rd_in && (fifo_cnt != '0);
        move        = en && hold_v && room;
        arrive      = en && frm_in;
        direct      = arrive && !hold_v && room;
        hold_load   = arrive && ((hold_v && move) || (!hold_v && !room));
        hold_unload = move;
        fifo_push   = move || direct;
        fifo_ent    = rxb_mark_ovr(move ? hold_ent : frm_ent, ovr_pend);
        ovr_evt     = en && start_in && hold_v && !room && !fifo_pop;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ovr_pend <= 1'b0;
        end else if (ovr_evt) begin
            ovr_pend <= 1'b1;
        end else if (fifo_push) begin
            ovr_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_ferr,
    input  logic              frm_perr,
    input  logic              start_seen,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ferr,
    output logic              rx_perr,
    output logic              rx_ovr,
    output logic              rx_done
);

    rxb_entry_t       in_ent;
    rxb_entry_t       push_ent;
    rxb_entry_t       head_ent;
    rxb_entry_t       hold_ent;
    logic             fifo_push;
    logic             fifo_pop;
    logic             hold_load;
    logic             hold_unload;
    logic             hold_v;
    logic             ovr_pend;
    logic [CNT_W-1:0] fifo_cnt;
    logic             flush;

    assign flush = !rx_en;

    always_comb begin
        in_ent      = RXB_EMPTY;
        in_ent.data = frm_data;
        in_ent.ferr = frm_ferr;
        in_ent.perr = frm_perr;
    end

    rxb_route #(.DEPTH(DEPTH)) u_route (
        .clk         (clk),
        .rst         (rst),
        .en          (rx_en),
        .frm_in      (frm_valid),
        .frm_ent     (in_ent),
        .start_in    (start_seen),
        .rd_in       (data_rd),
        .fifo_cnt    (fifo_cnt),
        .hold_v      (hold_v),
        .hold_ent    (hold_ent),
        .fifo_push   (fifo_push),
        .fifo_ent    (push_ent),
        .fifo_pop    (fifo_pop),
        .hold_load   (hold_load),
        .hold_unload (hold_unload),
        .ovr_pend    (ovr_pend)
    );

    rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (fifo_push),
        .push_ent (push_ent),
        .pop      (fifo_pop),
        .head_ent (head_ent),
        .count    (fifo_cnt)
    );

    rxb_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .load     (hold_load),
        .load_ent (in_ent),
        .unload   (hold_unload),
        .valid    (hold_v),
        .ent      (hold_ent)
    );

    always_comb begin
        rx_done = fifo_cnt != '0;
        if (rx_done) begin
            rx_data = head_ent.data;
            rx_ferr = head_ent.ferr;
            rx_perr = head_ent.perr;
            rx_ovr  = head_ent.ovr;
        end else begin
            rx_data = '0;
            rx_ferr = 1'b0;
            rx_perr = 1'b0;
            rx_ovr  = 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_buffer_chk.sv
module serial_rx_buffer_chk
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              frm_valid,
    input logic              start_seen,
    input logic              data_rd,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ferr,
    input logic              rx_perr,
    input logic              rx_ovr,
    input logic              rx_done,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              hold_v,
    input logic              ovr_pend
);

    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !rx_done); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(DEPTH)); // R2

    AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (rst)
        (!rx_done && data_rd && !frm_valid && !hold_v) |=> !rx_done); // R5

    AST_FULL_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rx_en && frm_valid && fifo_cnt == CNT_W'(DEPTH) && !hold_v) |=> hold_v); // R6

    AST_HOLD_MOVES: assert property (@(posedge clk) disable iff (rst)
        (rx_en && hold_v && fifo_cnt < CNT_W'(DEPTH) && !data_rd)
        |=> fifo_cnt == $past(fifo_cnt) + 1'b1); // R7

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_pend) |-> $past(start_seen && hold_v && fifo_cnt == CNT_W'(DEPTH) && !data_rd)); // R8

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_done && !hold_v && !ovr_pend)); // R11

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> (rx_data == '0 && !rx_ferr && !rx_perr && !rx_ovr)); // R12

endmodule

bind serial_rx_buffer serial_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .frm_valid  (frm_valid),
    .start_seen (start_seen),
    .data_rd    (data_rd),
    .rx_data    (rx_data),
    .rx_ferr    (rx_ferr),
    .rx_perr    (rx_perr),
    .rx_ovr     (rx_ovr),
    .rx_done    (rx_done),
    .fifo_cnt   (fifo_cnt),
    .hold_v     (hold_v),
    .ovr_pend   (ovr_pend)
);

// File: tb/sim_serial_rx_buffer.sv
module sim_serial_rx_buffer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       frm_valid = 1'b0;
    logic [8:0] frm_data = '0;
    logic       frm_ferr = 1'b0;
    logic       frm_perr = 1'b0;
    logic       start_seen = 1'b0;
    logic       data_rd = 1'b0;
    logic [8:0] rx_data;
    logic       rx_ferr;
    logic       rx_perr;
    logic       rx_ovr;
    logic       rx_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_rx_buffer u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .frm_valid(frm_valid),
        .frm_data(frm_data), .frm_ferr(frm_ferr), .frm_perr(frm_perr),
        .start_seen(start_seen), .data_rd(data_rd), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr), .rx_done(rx_done)
    );

    typedef struct packed {
        logic [31:0] tag;
        logic       en;
        logic       fv;
        logic [8:0] d;
        logic       fe;
        logic       pe;
        logic       st;
        logic       rd;
        logic       x_done;
        logic [8:0] x_d;
        logic       x_fe;
        logic       x_pe;
        logic       x_ov;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        //  tag   en    fv    d        fe    pe    st    rd    done  x_d      fe    pe    ov
        '{"R12",1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0,1'b0},
        '{"R4", 1'b1,1'b1,9'h011,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h011,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h022,1'b1,1'b0,1'b0,1'b0, 1'b1,9'h011,1'b0,1'b0,1'b0},
        '{"R6", 1'b1,1'b1,9'h133,1'b0,1'b1,1'b0,1'b0, 1'b1,9'h011,1'b0,1'b0,1'b0},
        '{"R8", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b1,1'b0, 1'b1,9'h011,1'b0,1'b0,1'b0},
        '{"R9", 1'b1,1'b1,9'h044,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h011,1'b0,1'b0,1'b0},
        '{"R3", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b1,9'h022,1'b1,1'b0,1'b0},
        '{"R7", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h022,1'b1,1'b0,1'b0},
        '{"R10",1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b1,9'h133,1'b0,1'b1,1'b1},
        '{"R5", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b0,9'h000,1'b0,1'b0,1'b0},
        '{"R5", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b0,9'h000,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h055,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h055,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h066,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h055,1'b0,1'b0,1'b0},
        '{"R6", 1'b1,1'b1,9'h077,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h055,1'b0,1'b0,1'b0},
        '{"R8", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b1,1'b1, 1'b1,9'h066,1'b0,1'b0,1'b0},
        '{"R7", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h066,1'b0,1'b0,1'b0},
        '{"R8", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b1,9'h077,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h088,1'b0,1'b0,1'b0,1'b1, 1'b1,9'h088,1'b0,1'b0,1'b0},
        '{"R11",1'b0,1'b1,9'h099,1'b0,1'b0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0,1'b0},
        '{"R11",1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h0A1,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h0A1,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h0A2,1'b0,1'b1,1'b0,1'b0, 1'b1,9'h0A1,1'b0,1'b0,1'b0},
        '{"R6", 1'b1,1'b1,9'h0A3,1'b1,1'b0,1'b0,1'b0, 1'b1,9'h0A1,1'b0,1'b0,1'b0},
        '{"R5", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b1,9'h0A2,1'b0,1'b1,1'b0},
        '{"R7", 1'b1,1'b1,9'h0A4,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h0A2,1'b0,1'b1,1'b0},
        '{"R7", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b1,9'h0A3,1'b1,1'b0,1'b0},
        '{"R7", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b1,9'h0A4,1'b0,1'b0,1'b0},
        '{"R4", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b0,9'h000,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h0B1,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h0B1,1'b0,1'b0,1'b0},
        '{"R2", 1'b1,1'b1,9'h0B2,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h0B1,1'b0,1'b0,1'b0},
        '{"R6", 1'b1,1'b1,9'h0B3,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h0B1,1'b0,1'b0,1'b0},
        '{"R8", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b1,1'b0, 1'b1,9'h0B1,1'b0,1'b0,1'b0},
        '{"R11",1'b0,1'b0,9'h000,1'b0,1'b0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0,1'b0},
        '{"R11",1'b1,1'b1,9'h0B4,1'b0,1'b0,1'b0,1'b0, 1'b1,9'h0B4,1'b0,1'b0,1'b0},
        '{"R5", 1'b1,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1, 1'b0,9'h000,1'b0,1'b0,1'b0}
    };

    task automatic compare(input logic [31:0] tag, input logic x_done,
                           input logic [8:0] x_d, input logic x_fe,
                           input logic x_pe, input logic x_ov);
        n_chk++;
        if ({rx_done, rx_data, rx_ferr, rx_perr, rx_ovr} !== {x_done, x_d, x_fe, x_pe, x_ov}) begin
            n_bad++;
            $display("FAIL %0s: actual done=%b data=%h fe=%b pe=%b ov=%b expected done=%b data=%h fe=%b pe=%b ov=%b",
                     tag, rx_done, rx_data, rx_ferr, rx_perr, rx_ovr,
                     x_done, x_d, x_fe, x_pe, x_ov);
        end
    endtask

    task automatic drive(input logic en, input logic fv, input logic [8:0] d,
                         input logic fe, input logic pe, input logic st, input logic rd);
        @(negedge clk);
        rx_en = en; frm_valid = fv; frm_data = d; frm_ferr = fe;
        frm_perr = pe; start_seen = st; data_rd = rd;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        compare("R1", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].en, VEC[i].fv, VEC[i].d, VEC[i].fe, VEC[i].pe, VEC[i].st, VEC[i].rd);
            compare(VEC[i].tag, VEC[i].x_done, VEC[i].x_d, VEC[i].x_fe, VEC[i].x_pe, VEC[i].x_ov);
        end

        // R1: reset in the middle of operation empties the queue
        drive(1'b1, 1'b1, 9'h1C5, 1'b1, 1'b1, 1'b0, 1'b0);
        compare("R3", 1'b1, 9'h1C5, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0);
        compare("R1", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R10: overrun with error-flagged held frame, then read through all
        drive(1'b1, 1'b1, 9'h101, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 9'h102, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 9'h103, 1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b1);
        compare("R10", 1'b1, 9'h102, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b1);
        compare("R10", 1'b1, 9'h103, 1'b1, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 9'h104, 1'b0, 1'b0, 1'b0, 1'b1);
        compare("R10", 1'b1, 9'h104, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b1);
        compare("R4", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (whole run): actual=still running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule